// File: doc/BRIEF.md
# Serial Flash Page-Program Engine with Dual-Role Buffer

This block drives a serial NOR flash over a four-wire SPI link (mode 0, most significant bit first) and owns a small byte buffer. The buffer has two roles. In the read-prefetch role it belongs to the read path, and this engine leaves it alone. In the program role it collects one full flash page from software, which pushes fixed-width words through a data port. A mode request input selects the role. The mode acknowledge output takes the new value only after the engine is idle and a fixed drain delay has passed. Software waits for the acknowledge before it uses the buffer in its new role.

Once the buffer is full, a buffered-program command sends a write-enable frame. It then releases chip select for a short gap and sends a page-program frame: the opcode, the address and every buffered byte. A second command writes one byte taken from a byte input. It is meant for the leftover bytes of a transfer that is not page aligned, and it is only accepted when the buffer is in the read-prefetch role. `busy` covers the whole serial sequence. Software polls the flash's own status afterwards.

Top module: `pwb_engine`

## Requirements
- R1: After reset, `busy`, `err_flag`, `mode_ack` and `spi_sck` are 0 and `spi_cs_n` is 1.
- R2: While the engine is idle, `mode_ack` takes the value of `mode_req` on the SWITCH_LAT-th rising clock edge after `mode_req` first differs from it (on the first edge when SWITCH_LAT is 0). It does not change before that edge.
- R3: `mode_ack` never changes while `busy` is 1. A request made during a command takes effect SWITCH_LAT edges after `busy` falls.
- R4: In the program role with the engine idle, each cycle with `push_valid` high stores one word. Pushes after the buffer is full (BUF_BYTES/4 words with the default 32-bit words) are ignored and do not disturb the stored data.
- R5: Buffered bytes go out in push order. Within a word the byte in bits 7:0 goes out first and the byte in bits 31:24 goes out last.
- R6: Command code 0x10 in the program role with a full buffer produces two chip-select frames. The first carries the single byte 0x06. Chip select is high for exactly CS_GAP clock cycles between the frames. The second frame carries 0x02, then the ADDR_BYTES address bytes with the most significant first, then all BUF_BYTES data bytes. Bits are stable at each rising `spi_sck` and go out most significant first.
- R7: Code 0x10 in the program role with a partly filled buffer sets `err_flag`, causes no chip-select activity and keeps the words already pushed.
- R8: `err_flag` clears on the edge on which a later command is accepted.
- R9: Code 0x90 in the read-prefetch role sends a 0x06 frame, then a frame with 0x02, the address and the single byte from `one_byte`.
- R10: Code 0x10 in the read-prefetch role, code 0x90 in the program role and any other code are ignored: no busy, no chip-select activity, no error.
- R11: `busy` rises on the edge that accepts a command and falls on the edge that releases chip select after the last bit. Chip select is low only while `busy` is high. Commands issued while busy are ignored.
- R12: A completed buffered program empties the buffer, so an immediate second 0x10 sets `err_flag`.
- R13: Entering the program role empties the buffer, and a later full page holds only words pushed after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Requested buffer role: 0 read prefetch, 1 program |
| mode_ack | output | 1 | Buffer role currently in force |
| push_valid | input | 1 | Push one word into the buffer this cycle |
| push_word | input | WORD_W | Word to push, lowest byte in bits 7:0 |
| addr_in | input | 8*ADDR_BYTES | Flash address for the next command |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code: 0x10 buffered program, 0x90 single byte |
| one_byte | input | 8 | Data byte for the single-byte command |
| busy | output | 1 | Serial sequence in progress |
| err_flag | output | 1 | Program command refused because the buffer was not full |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
A fill pointer in the wrong place appears one program later as a shifted or repeated page byte stream, or as a refused command when the buffer should have been full. The bench compares every byte of each captured frame with arithmetic patterns, so such a fault is reported at the end of that command. A fault in the role handshake shows at `mode_ack` on the edge where the change is due. The bench samples there, before the change is due and at the point where a busy period ends. Sequencer faults show inside a single command as a wrong frame count, frame length or chip-select gap.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_WREN,
      SQ_GAP,
      SQ_PROG
   } seq_state_t;

   localparam logic [7:0] FL_OP_WREN   = 8'h06;
   localparam logic [7:0] FL_OP_PAGE   = 8'h02;
   localparam logic [7:0] CMD_BUF_PGM  = 8'h10;
   localparam logic [7:0] CMD_ONE_BYTE = 8'h90;

endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
   parameter int BUF_BYTES = 128,
   parameter int WORD_W    = 32,
   localparam int IDX_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_en,
   input  logic [WORD_W-1:0] push_word,
   input  logic              clr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_byte,
   output logic              full
);
   localparam int LANES = WORD_W / 8;
   localparam int WORDS = BUF_BYTES / LANES;
   localparam int LB    = $clog2(LANES);
   localparam int WA    = $clog2(WORDS);
   localparam int PTR_W = WA + 1;

   if (WORD_W % 8 != 0 || LANES != (1 << LB)) begin : g_bad_word
      $error("pwb_buffer: WORD_W must be 8 times a power of two");
   end
   if (WORDS < 2 || WORDS != (1 << WA) || BUF_BYTES % LANES != 0) begin : g_bad_depth
      $error("pwb_buffer: BUF_BYTES must hold a power-of-two number of words, at least two");
   end

   logic [WORD_W-1:0] mem_q [WORDS];
   logic [PTR_W-1:0]  fill_q;
   logic [WORD_W-1:0] sel_word;
   logic [7:0]        lane_b [LANES];

   assign full = (fill_q == PTR_W'(WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (clr) begin
         fill_q <= '0;
      end else if (push_en && !full) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_en && !full && !clr) begin
         mem_q[fill_q[WA-1:0]] <= push_word;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_b[l] = sel_word[8*l +: 8];
   end

   if (LANES == 1) begin : g_byte_words
      assign sel_word = mem_q[rd_idx];
      assign rd_byte  = lane_b[0];
   end else begin : g_wide_words
      assign sel_word = mem_q[rd_idx[IDX_W-1:LB]];
      assign rd_byte  = lane_b[rd_idx[LB-1:0]];
   end

endmodule

// File: rtl/pwb_mode_ctrl.sv
module pwb_mode_ctrl #(
   parameter int SWITCH_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic idle,
   output logic role
);
   localparam int CW = (SWITCH_LAT > 1) ? $clog2(SWITCH_LAT) : 1;

   if (SWITCH_LAT < 0) begin : g_bad_lat
      $error("pwb_mode_ctrl: SWITCH_LAT must not be negative");
   end

   logic role_q;
   assign role = role_q;

   if (SWITCH_LAT == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            role_q <= 1'b0;
         end else if (idle) begin
            role_q <= req;
         end
      end
   end else begin : g_timed
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            role_q <= 1'b0;
            cnt_q  <= '0;
         end else if (!idle || req == role_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(SWITCH_LAT - 1)) begin
            role_q <= req;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwb_shifter.sv
module pwb_shifter #(
   parameter int SCK_HALF = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] din,
   output logic       ready,
   output logic       sck,
   output logic       mosi
);
   localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

   if (SCK_HALF < 1) begin : g_bad_half
      $error("pwb_shifter: SCK_HALF must be at least 1");
   end

   logic          active_q;
   logic          sck_q;
   logic [7:0]    sh_q;
   logic [2:0]    bits_q;
   logic [CW-1:0] hc_q;

   assign ready = !active_q;
   assign sck   = sck_q;
   assign mosi  = active_q & sh_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sck_q    <= 1'b0;
         sh_q     <= '0;
         bits_q   <= '0;
         hc_q     <= '0;
      end else if (!active_q) begin
         if (start) begin
            active_q <= 1'b1;
            sh_q     <= din;
            bits_q   <= 3'd7;
            hc_q     <= '0;
            sck_q    <= 1'b0;
         end
      end else if (hc_q == CW'(SCK_HALF - 1)) begin
         hc_q <= '0;
         if (!sck_q) begin
            sck_q <= 1'b1;
         end else begin
            sck_q <= 1'b0;
            if (bits_q == 3'd0) begin
               active_q <= 1'b0;
            end else begin
               bits_q <= bits_q - 1'b1;
               sh_q   <= {sh_q[6:0], 1'b0};
            end
         end
      end else begin
         hc_q <= hc_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
   import pwb_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int BUF_BYTES  = 128,
   parameter int WORD_W     = 32,
   parameter int SWITCH_LAT = 3,
   parameter int CS_GAP     = 2,
   parameter int SCK_HALF   = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_req,
   output logic                    mode_ack,
   input  logic                    push_valid,
   input  logic [WORD_W-1:0]       push_word,
   input  logic [8*ADDR_BYTES-1:0] addr_in,
   input  logic                    cmd_valid,
   input  logic [7:0]              cmd_code,
   input  logic [7:0]              one_byte,
   output logic                    busy,
   output logic                    err_flag,
   output logic                    spi_cs_n,
   output logic                    spi_sck,
   output logic                    spi_mosi
);
   localparam int ADDR_W    = 8 * ADDR_BYTES;
   localparam int HDR_LEN   = 1 + ADDR_BYTES;
   localparam int FRAME_BUF = HDR_LEN + BUF_BYTES;
   localparam int FRAME_ONE = HDR_LEN + 1;
   localparam int SQ_W      = $clog2(FRAME_BUF + 1);
   localparam int BIDX_W    = $clog2(BUF_BYTES);
   localparam int GW        = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("pwb_engine: ADDR_BYTES must lie in 1..4");
   end
   if (CS_GAP < 1) begin : g_bad_gap
      $error("pwb_engine: CS_GAP must be at least 1");
   end

   seq_state_t        st_q;
   logic              cs_n_q;
   logic              sent_q;
   logic [GW-1:0]     gap_q;
   logic [SQ_W-1:0]   idx_q;
   logic              is_buf_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        one_q;
   logic              err_q;

   logic              idle;
   logic              buf_full;
   logic [7:0]        buf_byte;
   logic              sh_ready;
   logic              sh_start;
   logic [7:0]        sh_din;
   logic [7:0]        pp_byte;
   logic [SQ_W-1:0]   frame_end;
   logic              accept_buf;
   logic              accept_one;
   logic              refuse_short;
   logic              pgm_done;

   assign idle     = (st_q == SQ_IDLE);
   assign busy     = !idle;
   assign err_flag = err_q;
   assign spi_cs_n = cs_n_q;

   pwb_mode_ctrl #(.SWITCH_LAT(SWITCH_LAT)) u_mode (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (mode_req),
      .idle (idle),
      .role (mode_ack)
   );

   pwb_buffer #(.BUF_BYTES(BUF_BYTES), .WORD_W(WORD_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (push_valid && mode_ack && idle),
      .push_word(push_word),
      .clr      (!mode_ack || pgm_done),
      .rd_idx   (BIDX_W'(idx_q - SQ_W'(HDR_LEN))),
      .rd_byte  (buf_byte),
      .full     (buf_full)
   );

   pwb_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .start(sh_start),
      .din  (sh_din),
      .ready(sh_ready),
      .sck  (spi_sck),
      .mosi (spi_mosi)
   );

   assign accept_buf   = cmd_valid && idle && cmd_code == CMD_BUF_PGM && mode_ack && buf_full;
   assign refuse_short = cmd_valid && idle && cmd_code == CMD_BUF_PGM && mode_ack && !buf_full;
   assign accept_one   = cmd_valid && idle && cmd_code == CMD_ONE_BYTE && !mode_ack;

   assign frame_end = is_buf_q ? SQ_W'(FRAME_BUF) : SQ_W'(FRAME_ONE);
   assign pgm_done  = (st_q == SQ_PROG) && sh_ready && (idx_q == frame_end) && is_buf_q;

   always_comb begin
      pp_byte = one_q;
      if (idx_q == '0) begin
         pp_byte = FL_OP_PAGE;
      end else if (idx_q < SQ_W'(HDR_LEN)) begin
         for (int b = 0; b < ADDR_BYTES; b++) begin
            if (idx_q == SQ_W'(b + 1)) begin
               pp_byte = addr_q[8*(ADDR_BYTES-1-b) +: 8];
            end
         end
      end else if (is_buf_q) begin
         pp_byte = buf_byte;
      end
   end

   assign sh_start = sh_ready &&
                     (((st_q == SQ_WREN) && !sent_q) ||
                      ((st_q == SQ_PROG) && (idx_q != frame_end)));
   assign sh_din   = (st_q == SQ_WREN) ? FL_OP_WREN : pp_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         cs_n_q   <= 1'b1;
         sent_q   <= 1'b0;
         gap_q    <= '0;
         idx_q    <= '0;
         is_buf_q <= 1'b0;
         addr_q   <= '0;
         one_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (accept_buf || accept_one) begin
                  st_q     <= SQ_WREN;
                  cs_n_q   <= 1'b0;
                  sent_q   <= 1'b0;
                  is_buf_q <= accept_buf;
                  addr_q   <= addr_in;
                  one_q    <= one_byte;
                  err_q    <= 1'b0;
               end else if (refuse_short) begin
                  err_q <= 1'b1;
               end
            end
            SQ_WREN: begin
               if (sh_ready && !sent_q) begin
                  sent_q <= 1'b1;
               end else if (sh_ready && sent_q) begin
                  cs_n_q <= 1'b1;
                  gap_q  <= '0;
                  st_q   <= SQ_GAP;
               end
            end
            SQ_GAP: begin
               if (gap_q == GW'(CS_GAP - 1)) begin
                  cs_n_q <= 1'b0;
                  idx_q  <= '0;
                  st_q   <= SQ_PROG;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            SQ_PROG: begin
               if (sh_ready) begin
                  if (idx_q == frame_end) begin
                     cs_n_q <= 1'b1;
                     st_q   <= SQ_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pwb_engine_chk.sv
module pwb_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic err_flag,
   input logic mode_ack,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi
);

   // R11: the flash is selected only inside a busy period
   p_cs_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> busy);

   // R11: busy ends on the same edge that deselects the flash
   p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $rose(spi_cs_n));

   // R6: the serial clock idles low while deselected
   p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R6: data is already settled when the serial clock rises
   p_mosi_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> $stable(spi_mosi));

   // R3: the buffer role is frozen during a command
   p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(mode_ack));

   // R7: a refused command starts nothing
   p_err_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> !busy);

endmodule

bind pwb_engine pwb_engine_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .err_flag(err_flag),
   .mode_ack(mode_ack),
   .spi_cs_n(spi_cs_n),
   .spi_sck (spi_sck),
   .spi_mosi(spi_mosi)
);

// File: tb/pwb_engine_tb.sv
module pwb_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AB  = 3;
   localparam int BB  = 128;
   localparam int WW  = 32;
   localparam int LAT = 3;
   localparam int GAP = 2;
   localparam int NW  = BB / (WW / 8);
   localparam int FMAX = 140;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_req = 1'b0;
   logic          push_valid = 1'b0;
   logic [WW-1:0] push_word = '0;
   logic [8*AB-1:0] addr_in = '0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_code = '0;
   logic [7:0]    one_byte = '0;
   logic          mode_ack, busy, err_flag, cs_n, sck, mosi;

   pwb_engine #(.ADDR_BYTES(AB), .BUF_BYTES(BB), .WORD_W(WW), .SWITCH_LAT(LAT),
                .CS_GAP(GAP), .SCK_HALF(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_ack(mode_ack),
      .push_valid(push_valid), .push_word(push_word), .addr_in(addr_in),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .one_byte(one_byte),
      .busy(busy), .err_flag(err_flag), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // frame capture
   logic [7:0] fb [2][FMAX];
   int   fbytes [2];
   int   nfr = 0;
   int   nb = 0;
   logic [7:0] shv = '0;
   bit   frame_open = 0;
   int   cs_falls = 0;
   int   gap_cnt = 0;

   always @(negedge cs_n) begin
      frame_open = 1;
      cs_falls++;
      nb = 0;
   end

   always @(posedge cs_n) begin
      if (frame_open) begin
         frame_open = 0;
         nfr++;
      end
   end

   always @(posedge sck) begin
      if (cs_n === 1'b0) begin
         shv = {shv[6:0], mosi};
         nb++;
         if (nb == 8) begin
            nb = 0;
            if (nfr < 2) begin
               if (fbytes[nfr] < FMAX) fb[nfr][fbytes[nfr]] = shv;
               fbytes[nfr]++;
            end
         end
      end
   end

   always @(posedge clk) begin
      if (busy === 1'b1 && cs_n === 1'b1) gap_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int k);
      return 8'((seed * 29 + k * 7 + k / 5) & 255);
   endfunction

   function automatic logic [WW-1:0] word_of(input int seed, input int w);
      return {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)};
   endfunction

   task automatic clear_cap();
      nfr = 0; fbytes[0] = 0; fbytes[1] = 0; nb = 0;
      cs_falls = 0; gap_cnt = 0; frame_open = 0;
   endtask

   task automatic push_words(input int seed, input int from, input int upto);
      for (int w = from; w < upto; w++) begin
         @(negedge clk);
         push_valid = 1'b1;
         push_word  = word_of(seed, w);
      end
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic issue(input logic [7:0] code);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = code;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int g = 0; g < 10000 && busy; g++) @(negedge clk);
   endtask

   task automatic set_mode(input logic v);
      @(negedge clk);
      mode_req = v;
      for (int i = 1; i <= LAT; i++) begin
         @(negedge clk);
         if (i == LAT) chk(mode_ack == v, "R2 ack after latency", mode_ack, v);
         else chk(mode_ack == !v, "R2 ack held early", mode_ack, !v);
      end
   endtask

   task automatic check_buf_frames(input int seed, input logic [8*AB-1:0] addr);
      int mism = 0;
      chk(nfr == 2, "R6 frame count", nfr, 2);
      chk(fbytes[0] == 1 && fb[0][0] == 8'h06, "R6 write-enable frame", fb[0][0], 8'h06);
      chk(gap_cnt == GAP, "R6 deselect gap", gap_cnt, GAP);
      chk(fbytes[1] == 1 + AB + BB, "R6 program frame length", fbytes[1], 1 + AB + BB);
      chk(fb[1][0] == 8'h02, "R6 page opcode", fb[1][0], 8'h02);
      chk({fb[1][1], fb[1][2], fb[1][3]} == addr, "R6 address bytes",
          {fb[1][1], fb[1][2], fb[1][3]}, addr);
      for (int k = 0; k < BB; k++) if (fb[1][1+AB+k] != pat(seed, k)) mism++;
      chk(mism == 0, "R5 data byte order", mism, 0);
   endtask

   task automatic run_buf(input int seed, input logic [8*AB-1:0] addr, input int extra);
      clear_cap();
      addr_in = addr;
      push_words(seed, 0, NW);
      if (extra > 0) push_words(seed + 100, 0, extra);
      issue(8'h10);
      chk(busy == 1'b1, "R11 busy after accept", busy, 1);
      chk(err_flag == 1'b0, "R8 no error on accept", err_flag, 0);
      wait_idle();
      @(negedge clk);
      check_buf_frames(seed, addr);
   endtask

   task automatic expect_ignored(input logic [7:0] code, input string tag);
      clear_cap();
      issue(code);
      repeat (4) @(negedge clk);
      chk(busy == 1'b0 && cs_falls == 0 && err_flag == 1'b0, tag, cs_falls, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      fbytes[0] = 0; fbytes[1] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && err_flag == 0 && mode_ack == 0, "R1 status at reset",
          {busy, err_flag, mode_ack}, 0);
      chk(cs_n == 1 && sck == 0, "R1 link idle at reset", {cs_n, sck}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);

      set_mode(1'b1);                                // R2

      for (int s = 0; s < 4; s++)                    // R5 R6 sweep
         run_buf(s * 37 + 1, 24'(s * 24'h13579B + 24'h00F00D), 0);

      run_buf(77, 24'hABCDEF, 3);                    // R4 overflow pushes ignored

      // R12, R7, R8
      clear_cap();
      issue(8'h10);
      chk(err_flag == 1'b1, "R12 buffer empty after program", err_flag, 1);
      chk(cs_falls == 0 && busy == 0, "R7 refused command silent", cs_falls, 0);
      push_words(55, 0, 10);
      issue(8'h10);
      chk(err_flag == 1'b1 && cs_falls == 0, "R7 partial fill refused", err_flag, 1);
      push_words(55, 10, NW);
      addr_in = 24'h000100;
      issue(8'h10);
      chk(err_flag == 1'b0, "R8 error cleared on accept", err_flag, 0);
      chk(busy == 1'b1, "R11 busy after accept", busy, 1);
      wait_idle();
      @(negedge clk);
      check_buf_frames(55, 24'h000100);              // R7 partial fill kept

      // R13
      push_words(9, 0, 5);
      set_mode(1'b0);
      set_mode(1'b1);
      run_buf(91, 24'h7E0042, 0);

      // R10 in program role
      expect_ignored(8'h90, "R10 single-byte code in program role");
      expect_ignored(8'h33, "R10 unknown code");

      set_mode(1'b0);
      expect_ignored(8'h10, "R10 buffered code in prefetch role");

      // R9 sweep over every byte value
      for (int v = 0; v < 256; v++) begin
         logic [8*AB-1:0] a;
         logic [7:0] e;
         bit ok;
         a = 24'(v * 24'h010101 + 24'h102030);
         e = 8'(v) ^ 8'h5A;
         clear_cap();
         addr_in  = a;
         one_byte = e;
         issue(8'h90);
         wait_idle();
         @(negedge clk);
         ok = nfr == 2 && fbytes[0] == 1 && fb[0][0] == 8'h06 && gap_cnt == GAP &&
              fbytes[1] == AB + 2 && fb[1][0] == 8'h02 &&
              {fb[1][1], fb[1][2], fb[1][3]} == a && fb[1][4] == e;
         chk(ok, "R9 single byte frame", fb[1][4], e);
      end

      // R3 and R11 together
      begin
         int bad = 0;
         clear_cap();
         one_byte = 8'hC3;
         addr_in  = 24'h00A5A5;
         issue(8'h90);
         mode_req = 1'b1;
         issue(8'h90);
         while (busy) begin
            if (mode_ack != 1'b0) bad++;
            @(negedge clk);
         end
         chk(bad == 0 && mode_ack == 1'b0, "R3 role frozen while busy", bad, 0);
         chk(nfr == 2 && cs_falls == 2, "R11 command while busy ignored", cs_falls, 2);
         chk(fb[1][4] == 8'hC3, "R9 byte after busy command", fb[1][4], 8'hC3);
         repeat (LAT - 1) @(negedge clk);
         chk(mode_ack == 1'b0, "R3 deferred switch not early", mode_ack, 0);
         @(negedge clk);
         chk(mode_ack == 1'b1, "R3 deferred switch applied", mode_ack, 1);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule